// File: doc/BRIEF.md
# Upper Memory Chip Select and Write Byte Strobe Unit

This unit sits in the bus interface of a 16-bit processor with a 20-bit address. It drives an active-low select for a programmable upper memory region and an active-low flag for bus cycles that touch the lowest 64 KB. It also drives two active-low write strobes, one for each byte lane of the data bus. Every output comes with an output enable for the pad.

The upper region always ends at address FFFFFh. Its size can be 64, 128, 256 or 512 KB. It leaves reset at 64 KB, so a fetch of the boot vector at FFFF0h selects it. The region select and the zero flag are captured at the start of each bus cycle and kept until the cycle ends. Bus hold forces the region select inactive.

Two request pins are sampled as reset is released. If both are low, the unit enters a quiet mode in which every output is tristated until the next reset.

Top module: `upper_cs_strobe`

## Requirements
- R1: After reset the size code is 0 (64 KB), so a bus cycle whose start address lies in F0000h..FFFFFh (for example FFFF0h) drives `upsel_n` low, and EFFFFh does not.
- R2: Size codes on `size_wdata` select the region size: 0 = 64 KB, 1 = 128 KB, 2 = 256 KB, 3 = 512 KB. The region always ends at FFFFFh. A write with `size_we` high takes effect from the next clock edge.
- R3: A size write with a code from 4 to 7 (`size_wdata[2]` = 1) is ignored, and the previous size stays in force.
- R4: While `hold_ack` is high, `upsel_n` is high in the same cycle. When `hold_ack` is released, the captured select reappears.
- R5: On the clock edge where `cyc_start` is high, `upsel_n` is updated from the address. It then holds through address changes until the edge where `cyc_end` is high, which drives it high. If `cyc_start` and `cyc_end` are both high on the same edge, the start takes priority.
- R6: `zind_n` is captured on the `cyc_start` edge. It goes low only when address bits 19..16 are all zero, stays steady for the whole cycle, and returns high at `cyc_end`.
- R7: `wrhi_n` equals `bhe_n` OR `wr_n`, with no clock delay.
- R8: `wrlo_n` equals `addr[0]` OR `wr_n`, with no clock delay.
- R9: While `rst_n` is low, `wrhi_oe` and `wrlo_oe` are 0 and `upsel_oe` and `zind_oe` are 1.
- R10: `mreq0_n` and `mreq1_n` are sampled on the last clock edge with `rst_n` low. If both are 0, all four output enables are 0 from the first clock edge with `rst_n` high. Otherwise all four are 1.
- R11: Quiet mode persists regardless of bus activity, and only a new reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_ack | input | 1 | Bus hold granted |
| cyc_start | input | 1 | Bus cycle start pulse |
| cyc_end | input | 1 | Bus cycle end pulse |
| addr | input | 20 | Latched bus address a19..a0 |
| bhe_n | input | 1 | Byte-high enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| mreq0_n | input | 1 | Quiet-mode request pin 0 |
| mreq1_n | input | 1 | Quiet-mode request pin 1 |
| size_we | input | 1 | Size register write enable |
| size_wdata | input | 3 | Size code to write |
| upsel_n | output | 1 | Upper region select, active low |
| upsel_oe | output | 1 | Output enable for upsel_n |
| zind_n | output | 1 | Zero-page indicator, active low |
| zind_oe | output | 1 | Output enable for zind_n |
| wrhi_n | output | 1 | Write high byte strobe, active low |
| wrhi_oe | output | 1 | Output enable for wrhi_n |
| wrlo_n | output | 1 | Write low byte strobe, active low |
| wrlo_oe | output | 1 | Output enable for wrlo_n |

## Verification
The timing of each result is as follows:
- `upsel_n` and `zind_n` change one clock edge after the edge that samples `cyc_start` or `cyc_end`.
- A size write is seen by the next cycle started after its edge.
- Quiet mode shows one edge after `rst_n` rises.
- The byte strobes and the bus hold override are combinational and settle within the same cycle.

The bench drives every input just after a falling edge and reads the registered results at the following falling edge, which is one rising edge later. It reads the combinational results 1 ns after changing their inputs.

// File: rtl/usel_pkg.sv
// Shared constants and the size-code type for the upper select unit.
// Assumes a 20-bit address and 64 KB granules.
package usel_pkg;
    localparam int ADDR_W = 20;
    localparam int BLK_W  = 16;
    localparam int SZC_W  = 2;
    localparam int WD_W   = SZC_W + 1;

    typedef enum logic [SZC_W-1:0] {
        SZ_64K  = 2'd0,
        SZ_128K = 2'd1,
        SZ_256K = 2'd2,
        SZ_512K = 2'd3
    } usel_size_e;
endpackage

// File: rtl/usel_mode_latch.sv
// Samples the two quiet-mode request pins on each reset cycle.
// On release it latches quiet mode if both pins were low.
// Assumes the pins are stable on the last reset clock edge.
module usel_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req0_n,
    input  logic req1_n,
    output logic quiet
);
    logic [1:0] samp;
    logic       in_rst;

    // Capture the pins during reset and decide the mode on the first free edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp   <= {req1_n, req0_n};
            in_rst <= 1'b1;
            quiet  <= 1'b0;
        end else begin
            in_rst <= 1'b0;
            if (in_rst) quiet <= (samp == 2'b00);
        end
    end

    // R11: once the decision is made, the mode never changes until reset.
    assert_mode_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rst |=> $stable(quiet));
endmodule

// File: rtl/usel_region_decode.sv
// Holds the region size code and captures the upper region hit at cycle start.
// Assumes addr_top carries the bits above the 64 KB granule.
module usel_region_decode
    import usel_pkg::*;
#(
    parameter int TOP_W = ADDR_W - BLK_W,
    parameter int SZ_W  = SZC_W,
    parameter int WDW   = WD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             cyc_end,
    input  logic [TOP_W-1:0] addr_top,
    input  logic             size_we,
    input  logic [WDW-1:0]   size_wdata,
    output logic             sel_q
);
    localparam logic [TOP_W-1:0] ONE = {{(TOP_W-1){1'b0}}, 1'b1};

    usel_size_e       sz;
    logic             legal_wr;
    logic [TOP_W-1:0] low_mask;
    logic             hit;

    // Accept only codes whose bits above the size field are zero.
    always_comb legal_wr = size_we && (size_wdata[WDW-1:SZ_W] == '0);

    // Size register: resets to 64 KB so the boot vector is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)        sz <= SZ_64K;
        else if (legal_wr) sz <= usel_size_e'(size_wdata[SZ_W-1:0]);
    end

    // Granule bits that the current size leaves free; the rest must be all ones.
    always_comb begin
        low_mask = (ONE << sz) - ONE;
        hit      = &(addr_top | low_mask);
    end

    // Capture the hit at cycle start and hold it until cycle end; start has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_q <= 1'b0;
        else if (cyc_start) sel_q <= hit;
        else if (cyc_end)   sel_q <= 1'b0;
    end

    // R3: an illegal code leaves the size unchanged.
    assert_size_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (size_we && size_wdata[WDW-1]) |=> $stable(sz));
    // R1: the top 64 KB is always inside the region.
    assert_top_granule_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && (&addr_top)) |=> sel_q);
    // R5: no start and no end means the select holds.
    assert_select_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && !cyc_end) |=> $stable(sel_q));
endmodule

// File: rtl/usel_strobe_gen.sv
// Registers the zero-page flag per cycle and forms the byte write strobes.
// Assumes bhe_n, wr_n and addr0 are already aligned to the bus cycle.
module usel_strobe_gen #(
    parameter int TOP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             cyc_end,
    input  logic [TOP_W-1:0] addr_top,
    input  logic             addr0,
    input  logic             bhe_n,
    input  logic             wr_n,
    output logic             zind_n,
    output logic             wrhi_n,
    output logic             wrlo_n
);
    logic zero_q;

    // Capture the all-zero test of the top address bits for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         zero_q <= 1'b0;
        else if (cyc_start) zero_q <= (addr_top == '0);
        else if (cyc_end)   zero_q <= 1'b0;
    end

    // Active-low outputs: zero flag and the two byte lane write strobes.
    always_comb begin
        zind_n = ~zero_q;
        wrhi_n = bhe_n | wr_n;
        wrlo_n = addr0 | wr_n;
    end

    // R6: the zero flag is steady inside a cycle.
    assert_zero_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && !cyc_end) |=> $stable(zind_n));
    // R7: a deasserted write strobe keeps the high lane strobe off.
    assert_hi_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |-> wrhi_n);
    // R8: a deasserted write strobe keeps the low lane strobe off.
    assert_lo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |-> wrlo_n);
endmodule

// File: rtl/upper_cs_strobe.sv
// Top of the upper select unit: region select, zero flag, byte strobes,
// and pad enables gated by quiet mode and reset.
// Assumes a synchronous active-low reset held for at least one clock edge.
module upper_cs_strobe
    import usel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_ack,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bhe_n,
    input  logic              wr_n,
    input  logic              mreq0_n,
    input  logic              mreq1_n,
    input  logic              size_we,
    input  logic [WD_W-1:0]   size_wdata,
    output logic              upsel_n,
    output logic              upsel_oe,
    output logic              zind_n,
    output logic              zind_oe,
    output logic              wrhi_n,
    output logic              wrhi_oe,
    output logic              wrlo_n,
    output logic              wrlo_oe
);
    localparam int TOP_W = ADDR_W - BLK_W;

    logic quiet;
    logic sel_q;
    logic unused_mid;

    assign unused_mid = ^addr[BLK_W-1:1];

    usel_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .req0_n (mreq0_n),
        .req1_n (mreq1_n),
        .quiet  (quiet)
    );

    usel_region_decode #(.TOP_W(TOP_W), .SZ_W(SZC_W), .WDW(WD_W)) u_region (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_start  (cyc_start),
        .cyc_end    (cyc_end),
        .addr_top   (addr[ADDR_W-1:BLK_W]),
        .size_we    (size_we),
        .size_wdata (size_wdata),
        .sel_q      (sel_q)
    );

    usel_strobe_gen #(.TOP_W(TOP_W)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .addr_top  (addr[ADDR_W-1:BLK_W]),
        .addr0     (addr[0]),
        .bhe_n     (bhe_n),
        .wr_n      (wr_n),
        .zind_n    (zind_n),
        .wrhi_n    (wrhi_n),
        .wrlo_n    (wrlo_n)
    );

    // Select output, forced inactive while bus hold is granted.
    always_comb upsel_n = ~(sel_q & ~hold_ack);

    // Pad enables: quiet mode turns all off, reset turns off the write strobes.
    always_comb begin
        upsel_oe = ~quiet;
        zind_oe  = ~quiet;
        wrhi_oe  = rst_n & ~quiet;
        wrlo_oe  = rst_n & ~quiet;
    end

    // R4: bus hold keeps the select inactive.
    assert_hold_inactive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> upsel_n);
    // R9: write strobes are tristated during reset.
    assert_reset_tristate_R9: assert property (@(posedge clk)
        !rst_n |-> (!wrhi_oe && !wrlo_oe));
    // R10: quiet mode turns off every enable together.
    assert_quiet_all_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upsel_oe |-> (!zind_oe && !wrhi_oe && !wrlo_oe));
endmodule

// File: tb/sim_upper_cs_strobe.sv
module sim_upper_cs_strobe;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_ack = 1'b0, cyc_start = 1'b0, cyc_end = 1'b0;
    logic [19:0] addr = '0;
    logic bhe_n = 1'b1, wr_n = 1'b1, mreq0_n = 1'b1, mreq1_n = 1'b1;
    logic size_we = 1'b0;
    logic [2:0] size_wdata = '0;
    logic upsel_n, upsel_oe, zind_n, zind_oe, wrhi_n, wrhi_oe, wrlo_n, wrlo_oe;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    upper_cs_strobe u0 (.*);

    // Vector: {size code[2:0], address[19:0], expected upsel_n, expected zind_n}
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {3'd0, 20'hFFFF0, 1'b0, 1'b1},
        {3'd0, 20'hF0000, 1'b0, 1'b1},
        {3'd0, 20'hEFFFF, 1'b1, 1'b1},
        {3'd1, 20'hE0000, 1'b0, 1'b1},
        {3'd1, 20'hDFFFF, 1'b1, 1'b1},
        {3'd2, 20'hC0000, 1'b0, 1'b1},
        {3'd2, 20'hBFFFF, 1'b1, 1'b1},
        {3'd3, 20'h80000, 1'b0, 1'b1},
        {3'd3, 20'h7FFFF, 1'b1, 1'b1},
        {3'd3, 20'h0FFFF, 1'b1, 1'b0},
        {3'd0, 20'h00000, 1'b1, 1'b0},
        {3'd3, 20'h10000, 1'b1, 1'b1}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic p0, input logic p1);
        @(negedge clk);
        rst_n = 1'b0; mreq0_n = p0; mreq1_n = p1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; mreq0_n = 1'b1; mreq1_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_size(input logic [2:0] code);
        size_we = 1'b1; size_wdata = code;
        @(negedge clk);
        size_we = 1'b0;
    endtask

    task automatic start_cycle(input logic [19:0] a);
        cyc_start = 1'b1; addr = a;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic end_cycle();
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: enables while reset is held
        repeat (2) @(negedge clk);
        chk(wrhi_oe, 0, "R9 wrhi_oe in reset");
        chk(wrlo_oe, 0, "R9 wrlo_oe in reset");
        chk(upsel_oe, 1, "R9 upsel_oe in reset");
        chk(zind_oe, 1, "R9 zind_oe in reset");
        do_reset(1'b1, 1'b1);
        chk(upsel_n, 1, "R1 idle select after reset");
        chk(zind_n, 1, "R6 idle zero flag after reset");
        // R1 boot vector with default size, no write
        start_cycle(20'hFFFF0);
        chk(upsel_n, 0, "R1 boot vector select");
        end_cycle();
        chk(upsel_n, 1, "R5 select cleared at end");

        // R2 / R6 table
        for (int i = 0; i < NV; i++) begin
            write_size(VEC[i][24:22]);
            start_cycle(VEC[i][21:2]);
            chk(upsel_n, VEC[i][1], $sformatf("R2 select vec %0d", i));
            chk(zind_n, VEC[i][0], $sformatf("R6 zero flag vec %0d", i));
            addr = ~VEC[i][21:2];
            @(negedge clk);
            chk(upsel_n, VEC[i][1], $sformatf("R5 select held vec %0d", i));
            chk(zind_n, VEC[i][0], $sformatf("R6 zero held vec %0d", i));
            end_cycle();
            chk(zind_n, 1, $sformatf("R6 zero cleared vec %0d", i));
        end

        // R3: illegal code ignored
        write_size(3'd0);
        write_size(3'd7);
        start_cycle(20'h80000);
        chk(upsel_n, 1, "R3 code 7 ignored");
        end_cycle();
        write_size(3'd3);
        write_size(3'd4);
        start_cycle(20'h80000);
        chk(upsel_n, 0, "R3 code 4 ignored keeps 512K");

        // R4: bus hold overrides mid-cycle
        hold_ack = 1'b1; #1;
        chk(upsel_n, 1, "R4 hold forces high");
        @(negedge clk);
        chk(upsel_n, 1, "R4 hold still high");
        hold_ack = 1'b0; #1;
        chk(upsel_n, 0, "R4 select returns after hold");
        end_cycle();

        // R5: start wins over end on the same edge
        cyc_start = 1'b1; cyc_end = 1'b1; addr = 20'hFFFFF;
        @(negedge clk);
        cyc_start = 1'b0; cyc_end = 1'b0;
        chk(upsel_n, 0, "R5 start priority");
        end_cycle();

        // R7 / R8: strobe truth tables
        for (int k = 0; k < 4; k++) begin
            bhe_n = k[1]; wr_n = k[0]; addr = {19'h0, k[1]}; #1;
            chk(wrhi_n, k[1] | k[0], $sformatf("R7 wrhi combo %0d", k));
            chk(wrlo_n, k[1] | k[0], $sformatf("R8 wrlo combo %0d", k));
        end
        wr_n = 1'b0; bhe_n = 1'b0; addr = 20'h00001; #1;
        chk(wrhi_n, 0, "R7 high lane only");
        chk(wrlo_n, 1, "R8 odd address no low lane");
        wr_n = 1'b1; bhe_n = 1'b1;
        @(negedge clk);

        // R10: one pin low gives normal mode
        do_reset(1'b0, 1'b1);
        chk(upsel_oe, 1, "R10 single request normal");
        chk(wrlo_oe, 1, "R10 single request wrlo_oe");
        // R10: both low gives quiet mode
        do_reset(1'b0, 1'b0);
        chk(upsel_oe, 0, "R10 quiet upsel_oe");
        chk(zind_oe, 0, "R10 quiet zind_oe");
        chk(wrhi_oe, 0, "R10 quiet wrhi_oe");
        chk(wrlo_oe, 0, "R10 quiet wrlo_oe");
        // R11: persists through bus activity, cleared by a new reset
        start_cycle(20'hFFFF0);
        end_cycle();
        chk(upsel_oe, 0, "R11 quiet persists");
        do_reset(1'b1, 1'b1);
        chk(upsel_oe, 1, "R11 reset clears quiet");
        chk(wrhi_oe, 1, "R11 reset clears quiet wrhi");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule